// File: doc/BRIEF.md
# Scaled Watchdog Timer

This block is a countdown watchdog configured through three byte-wide registers on a small address/data/strobe bus. Software writes a count to arm it. A one-second tick input then decrements the count, either on every tick or once every `TICKS_PER_UNIT` ticks when the long time base is selected. When the count runs out, the block emits a one-cycle timeout pulse, sets a sticky fired flag and raises an interrupt request with a programmable routing code.

Several things can push the deadline back or fire the watchdog early. Mouse and keyboard interrupt pulses can reload the count when their enables are set. A self-clearing force bit triggers a timeout at once. A keyboard line can be allowed to force a timeout. The fired flag must be cleared by software before another timeout pulse can be produced. Unlocking the register space is handled outside this block.

Registers: TBASE at address 0 (bit 3 long time base, bit 2 keyboard-line force enable, other bits read 0), COUNT at address 1 (8-bit remaining count), MODE at address 2 (bit 7 mouse reload enable, bit 6 keyboard reload enable, bit 5 force, bit 4 fired status, bits 3:0 routing code).

Top module: `wdt_scaled`

## Requirements
- R1: After reset, TBASE, COUNT and MODE all read 0x00, and `wdt_expire`, `irq_req` and `smi_req` are low.
- R2: Writing a nonzero value N to COUNT (address 1) arms the timer. With TBASE bit 3 = 0, each tick decrements COUNT by one. The tick that takes COUNT from 1 to 0 produces a `wdt_expire` pulse exactly one cycle long, visible in the cycle after that tick, and COUNT then reads 0.
- R3: While COUNT holds 0, the watchdog is stopped and ticks change nothing.
- R4: Writing COUNT while the timer runs reloads it with the new value and restarts the long-scale prescaler.
- R5: With TBASE bit 3 = 1, COUNT decrements once every `TICKS_PER_UNIT` ticks, counted from the last COUNT write.
- R6: While armed, a `mouse_irq` pulse reloads COUNT with the last written value if MODE bit 7 is set, and a `kbd_irq` pulse does the same if MODE bit 6 is set. A pulse whose enable is clear is ignored, and so is any pulse while COUNT is 0.
- R7: Writing MODE with bit 5 set causes an immediate timeout: `wdt_expire` pulses in the next cycle and COUNT becomes 0. Bit 5 always reads 0.
- R8: MODE bit 4 is set by every timeout and stays set. Writing it as 0 clears it, and writing it as 1 leaves it unchanged. While it is set, no further `wdt_expire` pulse occurs, although a running count still stops at 0.
- R9: With TBASE bit 2 set, a high level on `kbd_p20` causes a timeout. With the bit clear, `kbd_p20` is ignored.
- R10: `irq_req` equals the fired status, `irq_route` equals MODE bits 3:0, and `smi_req` is high while the status is set and the routing code equals `SMI_CODE` (2).
- R11: The longest timeout, COUNT = 255 with the long time base, expires after exactly 255 × `TICKS_PER_UNIT` ticks.
- R12: `bus_rdata` presents the register selected by `bus_addr` one cycle after a cycle with `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 TBASE, 1 COUNT, 2 MODE |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| tick_1s | input | 1 | One-second tick, one cycle wide |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| kbd_p20 | input | 1 | Keyboard line that can force a timeout |
| wdt_expire | output | 1 | One-cycle timeout pulse |
| irq_req | output | 1 | Interrupt request, follows the fired status |
| irq_route | output | 4 | Interrupt routing code |
| smi_req | output | 1 | Request on the system-management route |

## Verification
The bench builds the block with `TICKS_PER_UNIT` = 5 and keeps `DW` = 8 and `SMI_CODE` = 2. The short divider places long-scale behaviour within a few thousand cycles: prescaler restart on COUNT rewrite, the four-tick hold before each decrement, and the full 255-count maximum timeout. The routing code 2 is compared against another nonzero code, so the system-management output is seen to separate the two.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_TBASE = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // TBASE field positions
  localparam int B_SCALE = 3;
  localparam int B_P20   = 2;
  // MODE field positions
  localparam int B_MOUSE = 7;
  localparam int B_KBD   = 6;
  localparam int B_FORCE = 5;
  localparam int B_STAT  = 4;
  localparam int ROUTE_W = 4;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic long_unit,
  input  logic tick,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic          at_top;

  assign at_top = (pre_q == PW'(DIV - 1));
  assign step   = tick && run && !restart && (!long_unit || at_top);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (tick && run && long_unit) begin
      pre_q <= at_top ? '0 : pre_q + 1'b1;
    end
  end

  // R5: a long-scale step always closes a full prescaler period
  p_long_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (step && long_unit) |=> (pre_q == '0));

  // R5: the prescaler never leaves its range
  p_pre_bound_r5: assert property (@(posedge clk) disable iff (rst)
    pre_q <= PW'(DIV - 1));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          reload,
  input  logic          step,
  input  logic          clear,
  output logic [DW-1:0] cnt,
  output logic          hit
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] rld_q;

  assign cnt = cnt_q;
  assign hit = step && (cnt_q == DW'(1)) && !load && !reload;

  // priority: timeout clear, software load, activity reload, step
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (load) rld_q <= load_val;
      if (clear)                        cnt_q <= '0;
      else if (load)                    cnt_q <= load_val;
      else if (reload)                  cnt_q <= rld_q;
      else if (step && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: a stopped counter stays stopped without a software load
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // R2: a plain step removes exactly one count
  p_step_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q > DW'(1) && !load && !reload && !clear)
      |=> (cnt_q == $past(cnt_q) - DW'(1)));
endmodule

// File: rtl/wdt_scaled.sv
module wdt_scaled
  import wdt_pkg::*;
#(
  parameter int DW             = 8,
  parameter int TICKS_PER_UNIT = 60,
  parameter int SMI_CODE       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_1s,
  input  logic          mouse_irq,
  input  logic          kbd_irq,
  input  logic          kbd_p20,
  output logic          wdt_expire,
  output logic          irq_req,
  output logic [3:0]    irq_route,
  output logic          smi_req
);
  localparam int RW = ROUTE_W;

  reg_sel_e sel;
  logic wr_tbase, wr_count, wr_mode;
  logic scale_q, p20en_q, mouse_en_q, kbd_en_q, status_q;
  logic [RW-1:0] route_q, route_d;
  logic status_d;
  logic [DW-1:0] cnt, rd_mux;
  logic step, hit, armed, act_reload, trig, gate, fire;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_tbase = bus_wr && (sel == SEL_TBASE);
  assign wr_count = bus_wr && (sel == SEL_COUNT);
  assign wr_mode  = bus_wr && (sel == SEL_MODE);

  assign armed      = (cnt != '0);
  assign act_reload = armed && ((mouse_en_q && mouse_irq) || (kbd_en_q && kbd_irq));

  wdt_prescale #(.DIV(TICKS_PER_UNIT)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .restart   (wr_count || act_reload),
    .run       (armed),
    .long_unit (scale_q),
    .tick      (tick_1s),
    .step      (step)
  );

  wdt_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_count),
    .load_val (bus_wdata),
    .reload   (act_reload),
    .step     (step),
    .clear    (fire),
    .cnt      (cnt),
    .hit      (hit)
  );

  // gate is the fired status after this cycle's software write
  assign trig     = hit || (wr_mode && bus_wdata[B_FORCE]) || (p20en_q && kbd_p20);
  assign gate     = wr_mode ? (status_q && bus_wdata[B_STAT]) : status_q;
  assign fire     = trig && !gate;
  assign status_d = fire || gate;
  assign route_d  = wr_mode ? bus_wdata[RW-1:0] : route_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q    <= 1'b0;
      p20en_q    <= 1'b0;
      mouse_en_q <= 1'b0;
      kbd_en_q   <= 1'b0;
      status_q   <= 1'b0;
      route_q    <= '0;
      wdt_expire <= 1'b0;
      irq_req    <= 1'b0;
      irq_route  <= '0;
      smi_req    <= 1'b0;
    end else begin
      if (wr_tbase) begin
        scale_q <= bus_wdata[B_SCALE];
        p20en_q <= bus_wdata[B_P20];
      end
      if (wr_mode) begin
        mouse_en_q <= bus_wdata[B_MOUSE];
        kbd_en_q   <= bus_wdata[B_KBD];
      end
      status_q   <= status_d;
      route_q    <= route_d;
      wdt_expire <= fire;
      irq_req    <= status_d;
      irq_route  <= route_d;
      smi_req    <= status_d && (route_d == RW'(SMI_CODE));
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_TBASE: begin
        rd_mux[B_SCALE] = scale_q;
        rd_mux[B_P20]   = p20en_q;
      end
      SEL_COUNT: rd_mux = cnt;
      SEL_MODE: begin
        rd_mux[B_MOUSE]  = mouse_en_q;
        rd_mux[B_KBD]    = kbd_en_q;
        rd_mux[B_STAT]   = status_q;
        rd_mux[RW-1:0]   = route_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2: the timeout pulse lasts one cycle
  p_expire_single_r2: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |=> !wdt_expire);

  // R8: a set, uncleared status blocks the next pulse
  p_status_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (status_q && !(wr_mode && !bus_wdata[B_STAT])) |=> !wdt_expire);

  // R10: every pulse comes with the interrupt request
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |-> irq_req);

  // R7: forcing a timeout empties a running count
  p_force_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_mode && bus_wdata[B_FORCE] && !status_q) |=> (cnt == '0));
endmodule

// File: tb/sim_wdt_scaled.sv
module sim_wdt_scaled;
  localparam int TPU = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic tick_1s = 1'b0, mouse_irq = 1'b0, kbd_irq = 1'b0, kbd_p20 = 1'b0;
  logic wdt_expire, irq_req, smi_req;
  logic [3:0] irq_route;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 0;

  wdt_scaled #(.DW(8), .TICKS_PER_UNIT(TPU), .SMI_CODE(2)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1s(tick_1s),
    .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .kbd_p20(kbd_p20),
    .wdt_expire(wdt_expire), .irq_req(irq_req), .irq_route(irq_route), .smi_req(smi_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares timeout pulses against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (wdt_expire) begin
        nchk++;
        if (exp_q.size() == 0) begin
          nfail++;
          $display("FAIL R2/R8 unexpected expiry actual=cycle %0d expected=none", cyc);
        end else if (exp_q[0] != cyc) begin
          nfail++;
          $display("FAIL R2 expiry timing actual=%0d expected=%0d", cyc, exp_q[0]);
          void'(exp_q.pop_front());
        end else begin
          void'(exp_q.pop_front());
        end
      end else if (exp_q.size() > 0 && exp_q[0] <= cyc) begin
        nchk++;
        nfail++;
        $display("FAIL R2 missing expiry actual=none expected=cycle %0d", exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit fires);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (fires) exp_q.push_back(cyc + 1);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tk(input bit fires);
    @(negedge clk);
    tick_1s = 1'b1;
    if (fires) exp_q.push_back(cyc + 1);
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic pulse_mouse();
    @(negedge clk); mouse_irq = 1'b1;
    @(negedge clk); mouse_irq = 1'b0;
  endtask

  task automatic pulse_kbd();
    @(negedge clk); kbd_irq = 1'b1;
    @(negedge clk); kbd_irq = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, {24'd0, v}, {24'd0, e});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R12: reset state through registered reads
    check("R1 expire", {31'd0, wdt_expire}, 0);
    check("R1 irq", {31'd0, irq_req}, 0);
    check("R1 smi", {31'd0, smi_req}, 0);
    expect_reg("R1/R12 TBASE", 2'd0, 8'h00);
    expect_reg("R1/R12 COUNT", 2'd1, 8'h00);
    expect_reg("R1/R12 MODE", 2'd2, 8'h00);

    // R2: short scale countdown
    wr(2'd1, 8'd3, 0);
    expect_reg("R2 loaded", 2'd1, 8'd3);
    tk(0); tk(0);
    expect_reg("R2 one left", 2'd1, 8'd1);
    tk(1);
    expect_reg("R2 count zero", 2'd1, 8'd0);
    expect_reg("R8 status set", 2'd2, 8'h10);
    check("R10 irq_req", {31'd0, irq_req}, 1);
    check("R10 no smi route0", {31'd0, smi_req}, 0);

    // R8: sticky status blocks a second pulse, count still stops
    wr(2'd1, 8'd2, 0);
    tk(0); tk(0);
    expect_reg("R8 blocked count zero", 2'd1, 8'd0);
    wr(2'd2, 8'h10, 0);
    expect_reg("R8 write1 keeps", 2'd2, 8'h10);
    wr(2'd2, 8'h00, 0);
    expect_reg("R8 write0 clears", 2'd2, 8'h00);
    check("R10 irq cleared", {31'd0, irq_req}, 0);

    // R3: disabled counter ignores ticks
    tk(0); tk(0); tk(0);
    expect_reg("R3 stays zero", 2'd1, 8'd0);

    // R4: rewrite while running reloads
    wr(2'd1, 8'd2, 0);
    tk(0);
    wr(2'd1, 8'd2, 0);
    tk(0);
    expect_reg("R4 reloaded", 2'd1, 8'd1);
    tk(1);
    wr(2'd2, 8'h00, 0);

    // R6: activity reloads
    wr(2'd2, 8'h80, 0);
    wr(2'd1, 8'd3, 0);
    tk(0);
    pulse_mouse();
    expect_reg("R6 mouse reload", 2'd1, 8'd3);
    wr(2'd2, 8'h40, 0);
    tk(0);
    pulse_mouse();
    expect_reg("R6 mouse ignored", 2'd1, 8'd2);
    pulse_kbd();
    expect_reg("R6 kbd reload", 2'd1, 8'd3);
    wr(2'd1, 8'd0, 0);
    wr(2'd2, 8'hC0, 0);
    pulse_mouse(); pulse_kbd();
    expect_reg("R6 idle ignores activity", 2'd1, 8'd0);
    wr(2'd2, 8'h00, 0);

    // R5: long scale
    wr(2'd0, 8'h08, 0);
    expect_reg("R5 TBASE readback", 2'd0, 8'h08);
    wr(2'd1, 8'd2, 0);
    for (int i = 0; i < TPU - 1; i++) tk(0);
    expect_reg("R5 holds before unit", 2'd1, 8'd2);
    tk(0);
    expect_reg("R5 one unit", 2'd1, 8'd1);
    for (int i = 0; i < TPU - 1; i++) tk(0);
    expect_reg("R5 holds second unit", 2'd1, 8'd1);
    tk(1);
    wr(2'd2, 8'h00, 0);

    // R4/R5: prescaler restart on COUNT write
    wr(2'd1, 8'd2, 0);
    for (int i = 0; i < 3; i++) tk(0);
    wr(2'd1, 8'd2, 0);
    for (int i = 0; i < TPU - 1; i++) tk(0);
    expect_reg("R4 prescaler restarted", 2'd1, 8'd2);
    tk(0);
    expect_reg("R4 step after restart", 2'd1, 8'd1);
    wr(2'd1, 8'd0, 0);
    wr(2'd0, 8'h00, 0);

    // R7 / R10: force with SMI routing
    wr(2'd2, 8'h22, 1);
    check("R10 smi_req", {31'd0, smi_req}, 1);
    check("R10 route", {28'd0, irq_route}, 32'd2);
    expect_reg("R7 force self-clears", 2'd2, 8'h12);
    wr(2'd2, 8'h02, 0);
    check("R10 smi drops", {31'd0, smi_req}, 0);
    wr(2'd2, 8'h23, 1);
    check("R10 other route no smi", {31'd0, smi_req}, 0);
    check("R10 other route irq", {31'd0, irq_req}, 1);
    wr(2'd2, 8'h00, 0);
    wr(2'd1, 8'd9, 0);
    wr(2'd2, 8'h20, 1);
    expect_reg("R7 force empties count", 2'd1, 8'd0);
    wr(2'd2, 8'h00, 0);

    // R9: keyboard line force
    wr(2'd0, 8'h04, 0);
    @(negedge clk);
    kbd_p20 = 1'b1;
    exp_q.push_back(cyc + 1);
    repeat (5) @(negedge clk);
    kbd_p20 = 1'b0;
    check("R9 p20 fired", {31'd0, irq_req}, 1);
    wr(2'd2, 8'h00, 0);
    wr(2'd0, 8'h00, 0);
    @(negedge clk);
    kbd_p20 = 1'b1;
    repeat (4) @(negedge clk);
    kbd_p20 = 1'b0;
    expect_reg("R9 p20 ignored", 2'd2, 8'h00);

    // R11: longest timeout
    wr(2'd0, 8'h08, 0);
    wr(2'd1, 8'd255, 0);
    for (int i = 1; i < 255 * TPU; i++) tk(0);
    expect_reg("R11 one unit left", 2'd1, 8'd1);
    tk(1);
    expect_reg("R11 expired", 2'd1, 8'd0);

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule